// File: doc/BRIEF.md
# Serial Transmitter with Idle and Break Sequencing

This block turns bytes into asynchronous serial characters on a single line output: one start bit at logic 0, the data bits least significant first, and one stop bit at logic 1. Every bit lasts a fixed number of pulses on a bit-rate tick input, so the baud-rate divider stays outside the block. Bytes arrive over a valid/ready port that backs a one-byte holding register. The ready output is the holding register's empty flag. A byte moves from the holding register into the shifter at the start of its character, and the next byte can then be written while that character is on the line.

Three control bits shape what goes on the line: a global interface enable, a transmitter enable and a send-break bit. Turning the transmitter on sends an idle character of all ones first. Turning it off and then on again while a character is in progress puts one idle character after that character. A short pulse on the send-break bit produces one all-zero character followed by one bit time of logic 1, so the receiver can find the next start bit. Holding the send-break bit produces a continuous run of break characters. Control writes only take effect while the global enable is high. Back-pressure follows the usual rule: a byte is taken on a cycle where both `in_valid` and `in_ready` are high. While the holding register is full, `in_ready` stays low and the upstream keeps its byte.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, `txd` is 1, `in_ready` is 1, and both `tx_en_q` and `brk_q` are 0.
- R2: A pulse on `ctl_wr` loads `ctl_tx_en` into `tx_en_q` and `ctl_brk` into `brk_q` only while `glob_en` is 1. When `glob_en` is 0, both bits keep their values.
- R3: A data character is DATA_W+2 bits: bit 0 is a start bit of 0, then the data bits with the least significant first, then a stop bit of 1. Each bit lasts exactly OSR bit-rate ticks.
- R4: `in_ready` goes low in the cycle after a byte is accepted. It goes high again when that byte enters the shifter. A byte that is already buffered when the previous character ends starts with no gap.
- R5: When `tx_en_q` goes from 0 to 1, one idle character (DATA_W+2 bit times of logic 1) is sent before any buffered data.
- R6: If `tx_en_q` is cleared and set again while a character is being sent, exactly one idle character follows that character before the next data character.
- R7: If `brk_q` is set and then cleared, one break character (DATA_W+2 bit times of logic 0) is sent. It is followed by exactly one bit time of logic 1 before the next character.
- R8: While `brk_q` stays 1, break characters follow each other with no logic-1 time between them.
- R9: If a break is requested before a pending idle preamble has started, the break is sent in place of the preamble.
- R10: While `tx_en_q` is 0, no new character starts and `txd` rests at 1. A character that has already started still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | Bit-rate tick, one pulse per sub-bit interval |
| glob_en | input | 1 | Global interface enable, gates control writes |
| ctl_wr | input | 1 | Control write strobe |
| ctl_tx_en | input | 1 | Transmitter-enable value to write |
| ctl_brk | input | 1 | Send-break value to write |
| tx_en_q | output | 1 | Current transmitter-enable bit |
| brk_q | output | 1 | Current send-break bit |
| in_valid | input | 1 | Byte offered by upstream |
| in_ready | output | 1 | Holding register empty; byte accepted when high with in_valid |
| in_data | input | DATA_W | Byte to send |
| txd | output | 1 | Serial line output |

## Verification
The bench builds the block with 8 data bits, OSR set to 4, and a tick on every third clock. A character therefore takes 120 clocks. This keeps the multi-character sequences short: a run of three held breaks, an enable toggle in the middle of a frame, and a break that replaces a preamble. Because OSR is above 1, the bench runs the counting tick divider and not the direct-tick variant. The short characters also let the gap before each character be counted exactly in ticks, which is how the invisible idle characters and the single trailing mark bit are measured.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [1:0] {
    CH_DATA  = 2'd0,
    CH_IDLE  = 2'd1,
    CH_BREAK = 2'd2,
    CH_MARK  = 2'd3
  } ch_kind_e;
endpackage

// File: rtl/uart_brk_ctl.sv
// Control bits with write gating; emits one-cycle pulses on enable and break rises.
module uart_brk_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic glob_en,
  input  logic ctl_wr,
  input  logic wr_tx_en,
  input  logic wr_brk,
  output logic tx_en_q,
  output logic brk_q,
  output logic en_rise,
  output logic brk_rise
);
  logic wr_ok;
  assign wr_ok = ctl_wr & glob_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en_q  <= 1'b0;
      brk_q    <= 1'b0;
      en_rise  <= 1'b0;
      brk_rise <= 1'b0;
    end else begin
      en_rise  <= 1'b0;
      brk_rise <= 1'b0;
      if (wr_ok) begin
        tx_en_q  <= wr_tx_en;
        brk_q    <= wr_brk;
        en_rise  <= wr_tx_en & ~tx_en_q;
        brk_rise <= wr_brk & ~brk_q;
      end
    end
  end
endmodule

// File: rtl/uart_brk_hold.sv
// One-byte holding register; its empty flag is the upstream ready.
module uart_brk_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              empty,
  output logic [DATA_W-1:0] hold_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      empty     <= 1'b1;
      hold_data <= '0;
    end else if (in_valid && empty) begin
      hold_data <= in_data;
      empty     <= 1'b0;
    end else if (take) begin
      empty <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_brk_seq.sv
// Chooses the next character at each boundary: break, trailing mark, preamble, data.
module uart_brk_seq
  import uart_brk_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 2,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               brk_on,
  input  logic               en_rise,
  input  logic               brk_rise,
  input  logic               have_data,
  input  logic [DATA_W-1:0]  hold_data,
  input  logic               busy,
  input  logic               char_end,
  output logic               load,
  output logic [FRAME_W-1:0] load_frame,
  output logic [LEN_W-1:0]   load_len,
  output logic               take
);
  logic     brk_req, pre_req, tail_req;
  logic     slot, want_brk, want_pre;
  ch_kind_e kind;

  always_comb begin
    slot     = (!busy || char_end) && tx_en;
    want_brk = brk_on | brk_req;
    want_pre = pre_req | en_rise;
    load     = 1'b0;
    take     = 1'b0;
    kind     = CH_DATA;
    if (slot) begin
      if (want_brk) begin
        load = 1'b1;
        kind = CH_BREAK;
      end else if (tail_req) begin
        load = 1'b1;
        kind = CH_MARK;
      end else if (want_pre) begin
        load = 1'b1;
        kind = CH_IDLE;
      end else if (have_data) begin
        load = 1'b1;
        take = 1'b1;
        kind = CH_DATA;
      end
    end
  end

  always_comb begin
    load_len = LEN_W'(FRAME_W);
    case (kind)
      CH_DATA:  load_frame = {1'b1, hold_data, 1'b0};
      CH_IDLE:  load_frame = '1;
      CH_BREAK: load_frame = '0;
      default: begin
        load_frame = '1;
        load_len   = LEN_W'(1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en) begin
      brk_req  <= 1'b0;
      pre_req  <= 1'b0;
      tail_req <= 1'b0;
    end else begin
      if (load && kind == CH_BREAK) brk_req <= 1'b0;
      else if (brk_rise)            brk_req <= 1'b1;

      if (load && (kind == CH_IDLE || kind == CH_BREAK)) pre_req <= 1'b0;
      else if (en_rise)                                  pre_req <= 1'b1;

      if (load && kind == CH_BREAK)     tail_req <= 1'b1;
      else if (load && kind == CH_MARK) tail_req <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_brk_shift.sv
// Frame shifter: OSR ticks per bit, LSB out first, reload on the last tick.
module uart_brk_shift #(
  parameter int FRAME_W = 10,
  parameter int OSR     = 16,
  parameter int LEN_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   len,
  output logic               busy,
  output logic               char_end,
  output logic               txd
);
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   left;
  logic               bit_done;

  generate
    if (OSR == 1) begin : g_direct
      assign bit_done = busy & tick;
    end else begin : g_div
      localparam int CW = $clog2(OSR);
      logic [CW-1:0] tcnt;
      always_ff @(posedge clk) begin
        if (!rst_n || load)  tcnt <= '0;
        else if (busy && tick)
          tcnt <= (tcnt == CW'(OSR - 1)) ? '0 : tcnt + CW'(1);
      end
      assign bit_done = busy & tick & (tcnt == CW'(OSR - 1));
    end
  endgenerate

  assign char_end = bit_done & (left == LEN_W'(1));
  assign txd      = ~busy | shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      shreg <= '1;
      left  <= '0;
    end else if (load) begin
      busy  <= 1'b1;
      shreg <= frame;
      left  <= len;
    end else if (bit_done) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      left  <= left - LEN_W'(1);
      if (left == LEN_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              glob_en,
  input  logic              ctl_wr,
  input  logic              ctl_tx_en,
  input  logic              ctl_brk,
  output logic              tx_en_q,
  output logic              brk_q,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  logic               en_rise, brk_rise;
  logic               empty, take;
  logic [DATA_W-1:0]  hold_data;
  logic               sh_busy, sh_end, sh_load;
  logic [FRAME_W-1:0] sh_frame;
  logic [LEN_W-1:0]   sh_len;

  uart_brk_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .ctl_wr(ctl_wr),
    .wr_tx_en(ctl_tx_en), .wr_brk(ctl_brk),
    .tx_en_q(tx_en_q), .brk_q(brk_q), .en_rise(en_rise), .brk_rise(brk_rise)
  );

  uart_brk_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .take(take), .empty(empty), .hold_data(hold_data)
  );

  assign in_ready = empty;

  uart_brk_seq #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en_q), .brk_on(brk_q),
    .en_rise(en_rise), .brk_rise(brk_rise), .have_data(~empty),
    .hold_data(hold_data), .busy(sh_busy), .char_end(sh_end),
    .load(sh_load), .load_frame(sh_frame), .load_len(sh_len), .take(take)
  );

  uart_brk_shift #(.FRAME_W(FRAME_W), .OSR(OSR), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(bit_tick), .load(sh_load),
    .frame(sh_frame), .len(sh_len), .busy(sh_busy), .char_end(sh_end),
    .txd(txd)
  );
endmodule

// File: rtl/uart_brk_chk.sv
module uart_brk_chk (
  input logic clk,
  input logic rst_n,
  input logic glob_en,
  input logic ctl_wr,
  input logic tx_en_q,
  input logic brk_q,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic sh_busy,
  input logic sh_load,
  input logic sh_end
);
  p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !glob_en) |=> ($stable(tx_en_q) && $stable(brk_q)));

  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> txd);

  p_no_start_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en_q && !sh_busy) |=> !sh_busy);

  p_load_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |-> tx_en_q);

  p_held_break_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_end && !txd && brk_q && tx_en_q) |=> (sh_busy && !txd));
endmodule

bind uart_brk_tx uart_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .glob_en(glob_en), .ctl_wr(ctl_wr),
  .tx_en_q(tx_en_q), .brk_q(brk_q), .in_valid(in_valid), .in_ready(in_ready),
  .txd(txd), .sh_busy(sh_busy), .sh_load(sh_load), .sh_end(sh_end)
);

// File: tb/tb_uart_brk_tx.sv
module tb_uart_brk_tx;
  localparam int DATA_W   = 8;
  localparam int OSR      = 4;
  localparam int TICK_DIV = 3;
  localparam int FRAME_W  = DATA_W + 2;
  localparam int CH_S     = FRAME_W * OSR;
  localparam int K_DATA   = 0;
  localparam int K_BRK    = 2;
  localparam int BIG      = 1000000;

  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, glob_en = 1'b0;
  logic ctl_wr = 1'b0, ctl_tx_en = 1'b0, ctl_brk = 1'b0, in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic tx_en_q, brk_q, in_ready, txd;

  uart_brk_tx #(.DATA_W(DATA_W), .OSR(OSR)) dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .glob_en(glob_en),
    .ctl_wr(ctl_wr), .ctl_tx_en(ctl_tx_en), .ctl_brk(ctl_brk),
    .tx_en_q(tx_en_q), .brk_q(brk_q), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .txd(txd)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  int q_kind[$], q_data[$], q_gmin[$], q_gmax[$];
  string q_req[$];
  int gap = 0, seen = 0, brk_seen = 0;
  bit in_ch = 1'b0;
  int cnt = 0;
  bit samp [CH_S];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_ch(input int k, input int d, input int gmin,
                           input int gmax, input string r);
    q_kind.push_back(k); q_data.push_back(d);
    q_gmin.push_back(gmin); q_gmax.push_back(gmax); q_req.push_back(r);
  endtask

  task automatic ctl_write(input bit en, input bit brk);
    ctl_tx_en = en; ctl_brk = brk; ctl_wr = 1'b1;
    cyc(1);
    ctl_wr = 1'b0;
  endtask

  task automatic send(input logic [DATA_W-1:0] d);
    while (!in_ready) cyc(1);
    in_valid = 1'b1; in_data = d;
    cyc(1);
    in_valid = 1'b0;
  endtask

  task automatic wait_seen(input int n);
    while (seen < n) cyc(1);
  endtask

  // bit-rate tick: one cycle high every TICK_DIV cycles
  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(posedge clk);
      #1 bit_tick = 1'b1;
      @(posedge clk);
      #1 bit_tick = 1'b0;
    end
  end

  // monitor: one line sample per tick, decoded into characters
  always @(negedge clk) begin
    if (rst_n && bit_tick) begin
      if (!in_ch) begin
        if (txd) gap++;
        else begin
          in_ch = 1'b1;
          samp[0] = 1'b0;
          cnt = 1;
        end
      end else begin
        samp[cnt] = txd;
        cnt++;
      end
      if (in_ch && cnt == CH_S) begin
        logic [FRAME_W-1:0] fr;
        bit steady;
        int kind, ek, ed, gmin, gmax;
        string r;
        steady = 1'b1;
        for (int b = 0; b < FRAME_W; b++) begin
          fr[b] = samp[b*OSR];
          for (int k = 1; k < OSR; k++)
            if (samp[b*OSR+k] != fr[b]) steady = 1'b0;
        end
        if (fr == '0) kind = K_BRK;
        else if (!fr[0] && fr[FRAME_W-1]) kind = K_DATA;
        else kind = 9;
        if (q_kind.size() == 0) begin
          chk(1'b0, "R10", "unexpected character", kind, -1);
        end else begin
          ek = q_kind.pop_front(); ed = q_data.pop_front();
          gmin = q_gmin.pop_front(); gmax = q_gmax.pop_front();
          r = q_req.pop_front();
          chk(steady, "R3", "bit held OSR ticks", 0, 1);
          chk(kind == ek, r, "character kind", kind, ek);
          if (ek == K_DATA)
            chk(int'(fr[DATA_W:1]) == ed, "R3", "data byte", int'(fr[DATA_W:1]), ed);
          chk(gap >= gmin && gap <= gmax, r, "ticks of mark before character", gap, gmin);
        end
        if (kind == K_BRK) brk_seen++;
        seen++;
        gap = 0;
        in_ch = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", seen, 13);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(tx_en_q == 1'b0, "R1", "tx_en_q after reset", tx_en_q, 0);
    chk(brk_q == 1'b0, "R1", "brk_q after reset", brk_q, 0);

    // R2: writes ignored with global enable low
    ctl_write(1'b1, 1'b1);
    cyc(2);
    chk(tx_en_q == 1'b0, "R2", "tx_en_q after gated write", tx_en_q, 0);
    chk(brk_q == 1'b0, "R2", "brk_q after gated write", brk_q, 0);

    // R10: byte buffered with transmitter off stays put, line high
    glob_en = 1'b1;
    send(8'hA5);
    chk(in_ready == 1'b0, "R4", "in_ready after accept", in_ready, 0);
    cyc(150);
    chk(txd == 1'b1, "R10", "line while disabled", txd, 1);
    chk(in_ready == 1'b0, "R10", "byte held while disabled", in_ready, 0);

    // R5: preamble before first data, then back-to-back bytes (R4)
    expect_ch(K_DATA, 'hA5, CH_S, CH_S + 1, "R5");
    expect_ch(K_DATA, 'h3C, 0, 0, "R4");
    expect_ch(K_DATA, 'h0F, 0, 0, "R4");
    gap = 0;
    ctl_write(1'b1, 1'b0);
    chk(tx_en_q == 1'b1, "R2", "tx_en_q after enabled write", tx_en_q, 1);
    send(8'h3C);
    send(8'h0F);
    wait_seen(3);

    // R6: enable toggled mid-frame queues one idle character
    expect_ch(K_DATA, 'h81, 0, BIG, "R3");
    expect_ch(K_DATA, 'h7E, CH_S, CH_S, "R6");
    send(8'h81);
    send(8'h7E);
    cyc(10);
    ctl_write(1'b0, 1'b0);
    ctl_write(1'b1, 1'b0);
    wait_seen(5);

    // R7: break pulse, then exactly one mark bit
    expect_ch(K_BRK, 0, 0, BIG, "R7");
    expect_ch(K_DATA, 'h55, OSR, OSR, "R7");
    ctl_write(1'b1, 1'b1);
    cyc(20);
    ctl_write(1'b1, 1'b0);
    send(8'h55);
    wait_seen(7);

    // R8: held break gives back-to-back breaks
    expect_ch(K_BRK, 0, 0, BIG, "R8");
    expect_ch(K_BRK, 0, 0, 0, "R8");
    expect_ch(K_BRK, 0, 0, 0, "R8");
    expect_ch(K_DATA, 'hC3, OSR, OSR, "R8");
    b0 = brk_seen;
    ctl_write(1'b1, 1'b1);
    while (brk_seen < b0 + 2) cyc(1);
    ctl_write(1'b1, 1'b0);
    send(8'hC3);
    wait_seen(11);

    // R9: break requested with the enable replaces the preamble
    ctl_write(1'b0, 1'b0);
    send(8'hE7);
    cyc(20);
    expect_ch(K_BRK, 0, 0, 1, "R9");
    expect_ch(K_DATA, 'hE7, OSR, OSR, "R9");
    gap = 0;
    ctl_write(1'b1, 1'b1);
    cyc(5);
    ctl_write(1'b1, 1'b0);
    wait_seen(13);

    cyc(200);
    chk(q_kind.size() == 0, "R3", "characters still expected", q_kind.size(), 0);
    chk(txd == 1'b1, "R10", "line idle at end", txd, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule